// File: doc/BRIEF.md
# Two-Wide Register Rename Unit

This block renames up to two instructions per cycle, translating 5-bit logical register numbers (32 logical registers) into 6-bit physical register numbers (38 physical registers). It keeps three structures: a map table that gives the current physical tag of each logical register, a FIFO of free physical tags, and a 20-entry in-order retirement queue. Each queue entry records whether an instruction writes a register and, if it does, the physical tag that its destination replaced.

Slot 0 is always the older of the two instructions presented in a cycle. Source lookups and destination allocations appear combinationally on the outputs in the same cycle. All table, list and queue updates happen at the next rising clock edge, and only when `stall` is low. The physical file has only six spare registers, so the unit often stalls on an empty free list. Commits return displaced tags to the free list, oldest first.

Top module: `rename_unit`

## Requirements
- R1: After synchronous reset, logical register n maps to physical tag n, the free list holds tags 32,33,34,35,36,37 in that order, the retirement queue is empty and `stall` is low.
- R2: A valid slot's source tags are the current map entries of its logical sources. A valid slot with a destination receives the tag at the head of the free list, taken in FIFO order. Slot 0 takes first, and if slot 0 takes none, slot 1 takes the head. The map holds the new tag from the next cycle on. Outputs are combinational in the same cycle.
- R3: When slot 1 reads a logical register that slot 0 writes in the same cycle, slot 1 gets slot 0's new tag. When both slots write the same logical register, slot 1's tag is the one that stays in the map, and slot 0's new tag is recorded as slot 1's displaced tag.
- R4: A valid slot with `in_has_dst` low takes no free tag and does not stall for lack of free tags. It still occupies one retirement entry.
- R5: `stall` is high when the number of valid slots with a destination exceeds the free-tag count. A stalled pair changes no state in either slot.
- R6: The retirement queue has 20 entries. `stall` is high when the number of valid slots exceeds the number of empty entries.
- R7: `commit_num` (0, 1, 2; 3 acts as 2, and the value is clipped to occupancy) retires the oldest entries in program order. The displaced tag of each retired entry that has a destination is appended to the tail of the free list, older entry first.
- R8: A tag freed by a commit is not available to a rename in the same cycle. The stall decision uses the free count from before the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 2 | Slot valid, bit i for slot i |
| in_has_dst | input | 2 | Slot writes a register |
| in_dst | input | 10 | Logical destination, slot i at bits [5i+4:5i] |
| in_src_a | input | 10 | Logical source A per slot |
| in_src_b | input | 10 | Logical source B per slot |
| commit_num | input | 2 | Number of oldest entries to retire |
| out_dst | output | 12 | New physical destination, slot i at bits [6i+5:6i] |
| out_src_a | output | 12 | Physical source A per slot |
| out_src_b | output | 12 | Physical source B per slot |
| stall | output | 1 | Pair refused this cycle |

## Verification
The source tags, destination tags and `stall` are due in the same cycle the inputs are applied. The bench drives inputs on the falling edge and compares those outputs 1 ns later, before the next rising edge. Map, free-list and queue effects are due one cycle after the accepting edge. The bench model advances its own map and queues at that edge and checks the effects through the next cycle's outputs. This is how the ordering of released tags (R7) and the one-cycle delay before a freed tag can be reused (R8) are observed.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int LOG_REGS   = 32;
    localparam int PHYS_REGS  = 38;
    localparam int ROB_DEPTH  = 20;
    localparam int LANES      = 2;
    localparam int LTAG_W     = $clog2(LOG_REGS);
    localparam int PTAG_W     = $clog2(PHYS_REGS);
    localparam int FREE_DEPTH = PHYS_REGS - LOG_REGS;
    localparam int FREE_CNT_W = $clog2(FREE_DEPTH + 1);
    localparam int ROB_CNT_W  = $clog2(ROB_DEPTH + 1);

    typedef logic [LTAG_W-1:0] ltag_t;
    typedef logic [PTAG_W-1:0] ptag_t;

    typedef struct packed {
        logic  has_dst;
        ptag_t old_tag;
    } retire_entry_t;

    function automatic logic [1:0] bits2(input logic [1:0] v);
        return {1'b0, v[0]} + {1'b0, v[1]};
    endfunction
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table
    import rn_pkg::*;
#(
    parameter int NREGS = LOG_REGS,
    parameter int NRD   = 6
) (
    input  logic  clk,
    input  logic  rst,
    input  ltag_t rd_idx [NRD],
    output ptag_t rd_tag [NRD],
    input  logic  we0,
    input  ltag_t wa0,
    input  ptag_t wd0,
    input  logic  we1,
    input  ltag_t wa1,
    input  ptag_t wd1
);
    ptag_t map_q [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) map_q[i] <= ptag_t'(i);
        end else begin
            if (we0) map_q[wa0] <= wd0;
            if (we1) map_q[wa1] <= wd1;   // younger slot wins
        end
    end

    always_comb begin
        for (int r = 0; r < NRD; r++) rd_tag[r] = map_q[rd_idx[r]];
    end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list
    import rn_pkg::*;
#(
    parameter int DEPTH = FREE_DEPTH,
    parameter int BASE  = LOG_REGS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             pop_n,
    input  logic [1:0]             push_n,
    input  ptag_t                  push_tag0,
    input  ptag_t                  push_tag1,
    output ptag_t                  head_tag0,
    output ptag_t                  head_tag1,
    output logic [FREE_CNT_W-1:0]  count
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    ptag_t            slots_q [DEPTH];
    logic [IDX_W-1:0] head_q, tail_q;

    function automatic logic [IDX_W-1:0] adv(input logic [IDX_W-1:0] i, input logic [1:0] s);
        logic [IDX_W:0] t;
        t = {1'b0, i} + (IDX_W+1)'(s);
        if (t >= (IDX_W+1)'(DEPTH)) t = t - (IDX_W+1)'(DEPTH);
        return t[IDX_W-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slots_q[i] <= ptag_t'(BASE + i);
            head_q <= '0;
            tail_q <= '0;
            count  <= FREE_CNT_W'(DEPTH);
        end else begin
            if (push_n != 2'd0) slots_q[tail_q] <= push_tag0;
            if (push_n == 2'd2) slots_q[adv(tail_q, 2'd1)] <= push_tag1;
            head_q <= adv(head_q, pop_n);
            tail_q <= adv(tail_q, push_n);
            count  <= count - FREE_CNT_W'(pop_n) + FREE_CNT_W'(push_n);
        end
    end

    assign head_tag0 = slots_q[head_q];
    assign head_tag1 = slots_q[adv(head_q, 2'd1)];

    // R5
    fl_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        FREE_CNT_W'(pop_n) <= count);
    // R7
    fl_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count <= FREE_CNT_W'(DEPTH));
endmodule

// File: rtl/rn_retire_queue.sv
module rn_retire_queue
    import rn_pkg::*;
#(
    parameter int DEPTH = ROB_DEPTH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            push_n,
    input  retire_entry_t         push_e0,
    input  retire_entry_t         push_e1,
    input  logic [1:0]            pop_req,
    output logic [1:0]            pop_n,
    output retire_entry_t         head_e0,
    output retire_entry_t         head_e1,
    output logic [ROB_CNT_W-1:0]  count
);
    localparam int IDX_W = $clog2(DEPTH);

    retire_entry_t    ent_q [DEPTH];
    logic [IDX_W-1:0] head_q, tail_q;
    logic [1:0]       req_sat;

    function automatic logic [IDX_W-1:0] adv(input logic [IDX_W-1:0] i, input logic [1:0] s);
        logic [IDX_W:0] t;
        t = {1'b0, i} + (IDX_W+1)'(s);
        if (t >= (IDX_W+1)'(DEPTH)) t = t - (IDX_W+1)'(DEPTH);
        return t[IDX_W-1:0];
    endfunction

    always_comb begin
        req_sat = (pop_req == 2'd3) ? 2'd2 : pop_req;
        pop_n   = (ROB_CNT_W'(req_sat) > count) ? count[1:0] : req_sat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
            head_q <= '0;
            tail_q <= '0;
            count  <= '0;
        end else begin
            if (push_n != 2'd0) ent_q[tail_q] <= push_e0;
            if (push_n == 2'd2) ent_q[adv(tail_q, 2'd1)] <= push_e1;
            head_q <= adv(head_q, pop_n);
            tail_q <= adv(tail_q, push_n);
            count  <= count + ROB_CNT_W'(push_n) - ROB_CNT_W'(pop_n);
        end
    end

    assign head_e0 = ent_q[head_q];
    assign head_e1 = ent_q[adv(head_q, 2'd1)];

    // R6
    rob_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count <= ROB_CNT_W'(DEPTH));
    // R7
    rob_order_chk: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> (pop_n == 2'd0));
endmodule

// File: rtl/rename_unit.sv
module rename_unit
    import rn_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [LANES-1:0]           in_valid,
    input  logic [LANES-1:0]           in_has_dst,
    input  logic [LANES*LTAG_W-1:0]    in_dst,
    input  logic [LANES*LTAG_W-1:0]    in_src_a,
    input  logic [LANES*LTAG_W-1:0]    in_src_b,
    input  logic [1:0]                 commit_num,
    output logic [LANES*PTAG_W-1:0]    out_dst,
    output logic [LANES*PTAG_W-1:0]    out_src_a,
    output logic [LANES*PTAG_W-1:0]    out_src_b,
    output logic                       stall
);
    ltag_t dst_l [LANES];
    ltag_t sa_l  [LANES];
    ltag_t sb_l  [LANES];
    ptag_t new_p [LANES];
    ptag_t sa_p  [LANES];
    ptag_t sb_p  [LANES];
    ptag_t old_p [LANES];

    ltag_t rd_idx [6];
    ptag_t rd_tag [6];

    logic [1:0] takes, need_fl, need_rob, fl_pop, fl_push, rob_push, rob_pop;
    logic       go, fr0, fr1;

    ptag_t                 fl_h0, fl_h1, fl_in0, fl_in1;
    logic [FREE_CNT_W-1:0] fl_count;
    logic [ROB_CNT_W-1:0]  rob_count;
    retire_entry_t         ent [LANES];
    retire_entry_t         rq_in0, rq_h0, rq_h1;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dst_l[i] = in_dst[i*LTAG_W +: LTAG_W];
        assign sa_l[i]  = in_src_a[i*LTAG_W +: LTAG_W];
        assign sb_l[i]  = in_src_b[i*LTAG_W +: LTAG_W];
        assign out_dst[i*PTAG_W +: PTAG_W]   = new_p[i];
        assign out_src_a[i*PTAG_W +: PTAG_W] = sa_p[i];
        assign out_src_b[i*PTAG_W +: PTAG_W] = sb_p[i];
        assign takes[i] = in_valid[i] & in_has_dst[i];
        assign ent[i]   = '{has_dst: in_has_dst[i], old_tag: old_p[i]};
    end

    // resource check: counts are the pre-commit values
    always_comb begin
        need_fl  = bits2(takes);
        need_rob = bits2(in_valid);
        stall    = (FREE_CNT_W'(need_fl) > fl_count) ||
                   (ROB_CNT_W'(need_rob) > (ROB_CNT_W'(ROB_DEPTH) - rob_count));
        go       = ~stall;
    end

    always_comb begin
        rd_idx[0] = sa_l[0];
        rd_idx[1] = sb_l[0];
        rd_idx[2] = sa_l[1];
        rd_idx[3] = sb_l[1];
        rd_idx[4] = dst_l[0];
        rd_idx[5] = dst_l[1];
    end

    rn_map_table u_map (
        .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_tag(rd_tag),
        .we0(go & takes[0]), .wa0(dst_l[0]), .wd0(new_p[0]),
        .we1(go & takes[1]), .wa1(dst_l[1]), .wd1(new_p[1])
    );

    // intra-pair consistency: slot 1 sees slot 0's allocation
    always_comb begin
        new_p[0] = fl_h0;
        new_p[1] = takes[0] ? fl_h1 : fl_h0;
        sa_p[0]  = rd_tag[0];
        sb_p[0]  = rd_tag[1];
        old_p[0] = rd_tag[4];
        sa_p[1]  = (takes[0] && sa_l[1]  == dst_l[0]) ? new_p[0] : rd_tag[2];
        sb_p[1]  = (takes[0] && sb_l[1]  == dst_l[0]) ? new_p[0] : rd_tag[3];
        old_p[1] = (takes[0] && dst_l[1] == dst_l[0]) ? new_p[0] : rd_tag[5];
    end

    // retire side: release displaced tags, older entry first
    always_comb begin
        fr0     = (rob_pop != 2'd0) && rq_h0.has_dst;
        fr1     = (rob_pop == 2'd2) && rq_h1.has_dst;
        fl_in0  = fr0 ? rq_h0.old_tag : rq_h1.old_tag;
        fl_in1  = rq_h1.old_tag;
        fl_push = bits2({fr1, fr0});
        fl_pop  = go ? need_fl : 2'd0;
        rob_push = go ? need_rob : 2'd0;
        rq_in0  = in_valid[0] ? ent[0] : ent[1];
    end

    rn_free_list u_free (
        .clk(clk), .rst(rst), .pop_n(fl_pop), .push_n(fl_push),
        .push_tag0(fl_in0), .push_tag1(fl_in1),
        .head_tag0(fl_h0), .head_tag1(fl_h1), .count(fl_count)
    );

    rn_retire_queue u_rq (
        .clk(clk), .rst(rst), .push_n(rob_push), .push_e0(rq_in0), .push_e1(ent[1]),
        .pop_req(commit_num), .pop_n(rob_pop), .head_e0(rq_h0), .head_e1(rq_h1),
        .count(rob_count)
    );

    // R5
    stall_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (stall && commit_num == 2'd0) |=> ($stable(fl_count) && $stable(rob_count)));
    // R3
    pair_distinct_chk: assert property (@(posedge clk) disable iff (rst)
        (go && takes == 2'b11) |-> (new_p[0] != new_p[1]));
    // R4
    nodst_keep_free_chk: assert property (@(posedge clk) disable iff (rst)
        (takes == 2'b00 && commit_num == 2'd0) |=> $stable(fl_count));
endmodule

// File: tb/rename_unit_test.sv
module rename_unit_test;
    import rn_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  in_valid = '0, in_has_dst = '0, commit_num = '0;
    logic [9:0]  in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic [11:0] out_dst, out_src_a, out_src_b;
    logic        stall;

    int total = 0;
    int bad   = 0;
    int mp [32];
    int fq [$];
    int rq_has [$];
    int rq_old [$];

    always #5 clk = ~clk;

    rename_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_has_dst(in_has_dst),
        .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .commit_num(commit_num), .out_dst(out_dst), .out_src_a(out_src_a),
        .out_src_b(out_src_b), .stall(stall)
    );

    task automatic chk(string lbl, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", lbl, act, exp);
        end
    endtask

    function automatic int exp_src(bit v0, bit h0, int d0, int s, int nt0);
        return (v0 && h0 && s == d0) ? nt0 : mp[s];
    endfunction

    task automatic step(string lbl, bit v0, bit h0, int d0, int a0, int b0,
                        bit v1, bit h1, int d1, int a1, int b1, int cm);
        int nd, nr, nt0, nt1, ncm;
        bit est;
        int freed [$];
        @(negedge clk);
        in_valid   = {v1, v0};
        in_has_dst = {h1, h0};
        in_dst     = {5'(d1), 5'(d0)};
        in_src_a   = {5'(a1), 5'(a0)};
        in_src_b   = {5'(b1), 5'(b0)};
        commit_num = 2'(cm);
        #1;
        nd  = int'(v0 && h0) + int'(v1 && h1);
        nr  = int'(v0) + int'(v1);
        est = (nd > fq.size()) || (nr > ROB_DEPTH - rq_has.size());
        chk({lbl, " R5 R6 stall"}, int'(stall), int'(est));
        nt0 = 0; nt1 = 0;
        if (!est) begin
            if (v0 && h0) nt0 = fq[0];
            if (v1 && h1) nt1 = (v0 && h0) ? fq[1] : fq[0];
            if (v0) begin
                chk({lbl, " R2 s0 srcA"}, int'(out_src_a[5:0]), mp[a0]);
                chk({lbl, " R2 s0 srcB"}, int'(out_src_b[5:0]), mp[b0]);
                if (h0) chk({lbl, " R2 s0 dst"}, int'(out_dst[5:0]), nt0);
            end
            if (v1) begin
                chk({lbl, " R3 s1 srcA"}, int'(out_src_a[11:6]), exp_src(v0, h0, d0, a1, nt0));
                chk({lbl, " R3 s1 srcB"}, int'(out_src_b[11:6]), exp_src(v0, h0, d0, b1, nt0));
                if (h1) chk({lbl, " R2 s1 dst"}, int'(out_dst[11:6]), nt1);
            end
        end
        @(posedge clk);
        ncm = (cm > 2) ? 2 : cm;
        if (ncm > rq_has.size()) ncm = rq_has.size();
        for (int k = 0; k < ncm; k++) begin
            if (rq_has[0] != 0) freed.push_back(rq_old[0]);
            void'(rq_has.pop_front());
            void'(rq_old.pop_front());
        end
        if (!est) begin
            if (v0) begin
                rq_has.push_back(int'(h0));
                rq_old.push_back(h0 ? mp[d0] : 0);
                if (h0) begin mp[d0] = nt0; void'(fq.pop_front()); end
            end
            if (v1) begin
                rq_has.push_back(int'(h1));
                rq_old.push_back(h1 ? mp[d1] : 0);
                if (h1) begin mp[d1] = nt1; void'(fq.pop_front()); end
            end
        end
        foreach (freed[k]) fq.push_back(freed[k]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        for (int i = 0; i < 32; i++) mp[i] = i;
        for (int i = 32; i < 38; i++) fq.push_back(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 stall after reset", int'(stall), 0);

        // R1 identity map and first allocation
        step("R1", 1, 1, 3, 5, 31, 0, 0, 0, 0, 0, 0);
        // R7 commit frees old tag 3 at the tail
        step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        step("R7", 1, 1, 4, 3, 4, 1, 1, 5, 4, 0, 0);
        step("R7", 1, 1, 6, 6, 7, 1, 1, 8, 8, 6, 0);
        step("R7", 1, 1, 9, 9, 1, 0, 0, 0, 0, 0, 0);
        step("R7", 1, 1, 10, 10, 3, 0, 0, 0, 0, 0, 0);
        // R5 free list empty: destination stalls
        step("R5", 1, 1, 11, 1, 2, 0, 0, 0, 0, 0, 0);
        step("R5", 0, 0, 0, 0, 0, 1, 1, 12, 1, 2, 0);
        // R4 no-destination pair proceeds with no free tag
        step("R4", 1, 0, 0, 4, 5, 1, 0, 0, 6, 9, 0);
        // R8 commit and rename same cycle with empty list: stall
        step("R8", 1, 1, 13, 1, 1, 0, 0, 0, 0, 0, 2);
        step("R8", 1, 1, 13, 1, 1, 0, 0, 0, 0, 0, 0);
        // R3 same destination in both slots, bypass into slot 1
        step("R3", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2);
        step("R3", 1, 1, 7, 7, 2, 1, 1, 7, 7, 7, 0);
        step("R3", 1, 0, 0, 7, 7, 0, 0, 0, 0, 0, 0);
        // R6 fill the queue with stores/branches
        for (int k = 0; k < 12; k++) step("R6", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3);
        for (int k = 0; k < 10; k++) step("R6", 1, 0, 0, k, k, 1, 0, 0, k, k, 0);
        step("R6", 1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        step("R6", 0, 0, 0, 0, 0, 1, 0, 0, 2, 2, 0);
        // R7 commit_num 3 acts as 2
        step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3);
        step("R7", 1, 1, 1, 1, 2, 1, 0, 0, 1, 1, 0);
        // random mix
        for (int n = 0; n < 4000; n++) begin
            int cmr;
            cmr = int'($urandom_range(0, 9));
            step("rand", 1'($urandom), 1'($urandom), int'($urandom_range(0, 31)),
                 int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                 1'($urandom), 1'($urandom), int'($urandom_range(0, 31)),
                 int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                 (cmr < 3) ? 0 : ((cmr < 6) ? 1 : ((cmr < 9) ? 2 : 3)));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule